// File: doc/BRIEF.md
# Codec Clock and Sample-Timing Generator

This block derives every timing strobe a voice-band codec front end needs from one fast master clock. A programmable divider first thins the master clock into an internal converter-clock enable. All later timing counts only on the cycles where that enable is high. A serial-clock enable is produced at a selectable fraction of the converter clock, and a one-cycle frame strobe marks each sample period. A second one-cycle strobe tells the DAC when to load its next word. That strobe sits a short, fixed distance ahead of the frame strobe, and it can be pulled further forward in steps of one thirty-second of the sample period.

Every output is a clock enable in the master-clock domain, so downstream logic runs on the same clock and qualifies its registers with these enables. The block has no data stream and therefore no valid/ready handshake. Its inputs are plain configuration fields and its outputs are plain strobes that cannot be stalled. Configuration fields are sampled only on the frame-strobe cycle, so a frame in progress is never shortened or stretched. The DAC advance field is taken only while the DAC power input is low.

Top module: `codec_clkgen`

## Requirements
- R1: `dmclk_en` is high for one master clock out of every M. M comes from `mdiv_code`: 000→1, 001→2, 010→3, 011→4, 100→5, and 101, 110, 111→1.
- R2: `sclk_en` is high on one `dmclk_en` cycle out of every S. S comes from `sclk_code`: 00→8, 01→4, 10→2, 11→1. The first `sclk_en` of a frame comes S converter-clock periods after the frame start, and `sclk_en` is also high on every `frame_sync` cycle.
- R3: `frame_sync` is high on one `dmclk_en` cycle out of every N. N comes from `rate_code`: 00→2048, 01→1024, 10→512, 11→256.
- R4: While `rst` is high, all four outputs are low. The active settings reset to code zero (M=1, S=8, N=2048, advance 0). After `rst` falls on a falling clock edge, the first `frame_sync` is seen 2047 falling edges later.
- R5: `dac_load` fires exactly once per frame. With advance 0 it fires S converter-clock periods before `frame_sync`.
- R6: An advance value a (0..31) moves `dac_load` earlier by a·N/32 converter-clock periods. The distance to `frame_sync` is (S + a·N/32) mod N. A distance of 0 puts `dac_load` on the `frame_sync` cycle.
- R7: The code fields are captured only on a `frame_sync` cycle. A change made during a frame leaves that frame's length unchanged and takes effect from the next frame.
- R8: `dac_adv` is captured at a frame boundary only while `dac_pwr` is low. While `dac_pwr` is high, the previously captured advance is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| mdiv_code | input | 3 | Master divide selection |
| sclk_code | input | 2 | Serial clock rate selection |
| rate_code | input | 2 | Sample rate selection |
| dac_adv | input | 5 | DAC load advance in 1/32 sample steps |
| dac_pwr | input | 1 | DAC powered; blocks advance updates when high |
| dmclk_en | output | 1 | Converter-clock enable |
| sclk_en | output | 1 | Serial-clock enable |
| frame_sync | output | 1 | One-cycle sample frame strobe |
| dac_load | output | 1 | One-cycle DAC load strobe |

## Verification
A bad master-divide count shows within five master cycles as a wrong gap between `dmclk_en` pulses. A bad sample counter or a decode error shows at the next frame boundary: the frame length is wrong, the frame does not coincide with a serial-clock pulse, or `dac_load` appears zero or two times in the frame or at the wrong distance. A configuration register that captures at the wrong moment shows as a frame of the wrong length right after the change, or as an advance that moves while the DAC is powered.

// File: rtl/codec_clk_pkg.sv
package codec_clk_pkg;
  localparam int MCODE_W = 3;
  localparam int SCODE_W = 2;
  localparam int RCODE_W = 2;
  localparam int ADV_W   = 5;
  localparam int MCNT_W  = 3;
  localparam int SCNT_W  = 11;

  typedef struct packed {
    logic [MCODE_W-1:0] mcode;
    logic [SCODE_W-1:0] scode;
    logic [RCODE_W-1:0] rcode;
    logic [ADV_W-1:0]   adv;
  } clk_cfg_t;

  // Master ratio minus one; reserved codes fall back to divide-by-one.
  function automatic logic [MCNT_W-1:0] mlast_of(input logic [MCODE_W-1:0] c);
    logic [MCNT_W-1:0] r;
    case (c)
      3'd1:    r = MCNT_W'(1);
      3'd2:    r = MCNT_W'(2);
      3'd3:    r = MCNT_W'(3);
      3'd4:    r = MCNT_W'(4);
      default: r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/cg_master_div.sv
module cg_master_div
  import codec_clk_pkg::*;
#(
  parameter int CNT_W = MCNT_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [MCODE_W-1:0] code,
  output logic               tick
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;

  always_comb last = CNT_W'(mlast_of(code));

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (cnt >= last) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick = !rst && (cnt >= last);
endmodule

// File: rtl/cg_cfg_hold.sv
module cg_cfg_hold
  import codec_clk_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     boundary,
  input  logic     dac_pwr,
  input  clk_cfg_t cfg_in,
  output clk_cfg_t cfg_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (boundary) begin
      cfg_q.mcode <= cfg_in.mcode;
      cfg_q.scode <= cfg_in.scode;
      cfg_q.rcode <= cfg_in.rcode;
      if (!dac_pwr) cfg_q.adv <= cfg_in.adv;
    end
  end
endmodule

// File: rtl/cg_sample_timer.sv
module cg_sample_timer
  import codec_clk_pkg::*;
#(
  parameter int CNT_W = SCNT_W,
  parameter int AW    = ADV_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic [RCODE_W-1:0] rcode,
  input  logic [SCODE_W-1:0] scode,
  input  logic [AW-1:0]      adv,
  output logic               frame,
  output logic               sclk,
  output logic               dac
);
  localparam logic [CNT_W-1:0] FULL  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] SBASE = CNT_W'(7);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  logic [CNT_W-1:0] smask;
  logic [CNT_W-1:0] step;
  logic [CNT_W-1:0] dpos;

  always_comb begin
    lim   = FULL >> rcode;
    smask = SBASE >> scode;
    step  = (lim >> AW) + 1'b1;
    dpos  = (lim - smask - 1'b1 - CNT_W'(adv) * step) & lim;
  end

  assign frame = tick && (cnt == lim);
  assign sclk  = tick && ((cnt & smask) == smask);
  assign dac   = tick && (cnt == dpos);

  always_ff @(posedge clk) begin
    if (rst)                       cnt <= '0;
    else if (tick && cnt >= lim)   cnt <= '0;
    else if (tick)                 cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/codec_clkgen.sv
module codec_clkgen
  import codec_clk_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [MCODE_W-1:0] mdiv_code,
  input  logic [SCODE_W-1:0] sclk_code,
  input  logic [RCODE_W-1:0] rate_code,
  input  logic [ADV_W-1:0]   dac_adv,
  input  logic               dac_pwr,
  output logic               dmclk_en,
  output logic               sclk_en,
  output logic               frame_sync,
  output logic               dac_load
);
  clk_cfg_t cfg_in;
  clk_cfg_t cfg_q;
  logic     tick;
  logic     frame;

  always_comb begin
    cfg_in.mcode = mdiv_code;
    cfg_in.scode = sclk_code;
    cfg_in.rcode = rate_code;
    cfg_in.adv   = dac_adv;
  end

  cg_cfg_hold u_cfg (
    .clk(clk), .rst(rst), .boundary(frame), .dac_pwr(dac_pwr),
    .cfg_in(cfg_in), .cfg_q(cfg_q)
  );

  cg_master_div #(.CNT_W(MCNT_W)) u_mdiv (
    .clk(clk), .rst(rst), .code(cfg_q.mcode), .tick(tick)
  );

  cg_sample_timer #(.CNT_W(SCNT_W), .AW(ADV_W)) u_timer (
    .clk(clk), .rst(rst), .tick(tick), .rcode(cfg_q.rcode),
    .scode(cfg_q.scode), .adv(cfg_q.adv),
    .frame(frame), .sclk(sclk_en), .dac(dac_load)
  );

  assign dmclk_en   = tick;
  assign frame_sync = frame;
endmodule

// File: rtl/codec_clkgen_chk.sv
module codec_clkgen_chk (
  input logic clk,
  input logic rst,
  input logic dmclk_en,
  input logic sclk_en,
  input logic frame_sync,
  input logic dac_load
);
  logic [2:0] gap;
  logic [1:0] dcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap  <= '0;
      dcnt <= '0;
    end else begin
      gap  <= dmclk_en ? 3'd0 : ((gap == 3'd7) ? gap : gap + 1'b1);
      if (frame_sync)             dcnt <= '0;
      else if (dac_load && dcnt != 2'd3) dcnt <= dcnt + 1'b1;
    end
  end

  // R4: outputs quiet in reset
  a_r4_quiet_in_reset: assert property (@(posedge clk)
    rst |-> (!dmclk_en && !sclk_en && !frame_sync && !dac_load));

  // R1: no more than four idle master cycles between converter enables
  a_r1_max_gap: assert property (@(posedge clk) disable iff (rst)
    (gap == 3'd4) |-> dmclk_en);

  // R2: serial enable only on converter enable cycles
  a_r2_sclk_on_dm: assert property (@(posedge clk) disable iff (rst)
    sclk_en |-> dmclk_en);

  // R2: frame aligned to a serial clock pulse
  a_r2_frame_on_sclk: assert property (@(posedge clk) disable iff (rst)
    frame_sync |-> sclk_en);

  // R3: frame strobe lasts one cycle
  a_r3_frame_single: assert property (@(posedge clk) disable iff (rst)
    frame_sync |=> !frame_sync);

  // R5: exactly one DAC load per frame
  a_r5_one_load: assert property (@(posedge clk) disable iff (rst)
    frame_sync |-> ((32'(dcnt) + 32'(dac_load)) == 1));
endmodule

bind codec_clkgen codec_clkgen_chk u_chk (
  .clk(clk), .rst(rst), .dmclk_en(dmclk_en), .sclk_en(sclk_en),
  .frame_sync(frame_sync), .dac_load(dac_load)
);

// File: tb/tb_codec_clkgen.sv
module tb_codec_clkgen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] mdiv_code = '0;
  logic [1:0] sclk_code = '0;
  logic [1:0] rate_code = '0;
  logic [4:0] dac_adv = '0;
  logic       dac_pwr = 1'b0;
  logic       dmclk_en, sclk_en, frame_sync, dac_load;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  codec_clkgen dut (
    .clk(clk), .rst(rst), .mdiv_code(mdiv_code), .sclk_code(sclk_code),
    .rate_code(rate_code), .dac_adv(dac_adv), .dac_pwr(dac_pwr),
    .dmclk_en(dmclk_en), .sclk_en(sclk_en), .frame_sync(frame_sync),
    .dac_load(dac_load)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000 && !done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, act=%0d exp<=200000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  function automatic int m_of(input int c);
    return (c >= 1 && c <= 4) ? c + 1 : 1;
  endfunction
  function automatic int s_of(input int c);
    return 8 >> c;
  endfunction
  function automatic int n_of(input int c);
    return 2048 >> c;
  endfunction
  function automatic int d_of(input int s, input int n, input int a);
    return (s + a * (n / 32)) % n;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wait_fs();
    int g = 0;
    do begin
      @(negedge clk);
      g++;
    end while (!frame_sync && g < 30000);
  endtask

  // Waits for a frame boundary, then measures the frame after it.
  task automatic measure(input int m, input int s, input int n, input int d);
    int t = 0, last_dm = 0, dm_bad = 0, sck_first = -1, sck_n = 0;
    int dac_n = 0, dac_t = -1, fs_t = -1;
    wait_fs();
    while (fs_t < 0 && t < n * m + 16) begin
      @(negedge clk);
      t++;
      if (dmclk_en) begin
        if (t - last_dm != m) dm_bad++;
        last_dm = t;
      end
      if (sclk_en) begin
        if (sck_first < 0) sck_first = t;
        sck_n++;
      end
      if (dac_load) begin
        dac_n++;
        dac_t = t;
      end
      if (frame_sync) fs_t = t;
    end
    chk(fs_t == n * m, "R3 frame length", fs_t, n * m);
    chk(dm_bad == 0, "R1 enable spacing", dm_bad, 0);
    chk(sck_first == s * m, "R2 first serial pulse", sck_first, s * m);
    chk(sck_n == n / s, "R2 serial pulses per frame", sck_n, n / s);
    chk(dac_n == 1, "R5 loads per frame", dac_n, 1);
    chk(dac_t == (n - d) * m, "R6 load position", dac_t, (n - d) * m);
  endtask

  task automatic set_cfg(input int mc, input int sc, input int rc, input int a, input bit p);
    @(negedge clk);
    mdiv_code = 3'(mc);
    sclk_code = 2'(sc);
    rate_code = 2'(rc);
    dac_adv   = 5'(a);
    dac_pwr   = p;
  endtask

  initial begin
    int k;
    repeat (3) @(negedge clk);
    // R4: quiet during reset
    chk({dmclk_en, sclk_en, frame_sync, dac_load} == 4'b0, "R4 reset outputs",
        int'({dmclk_en, sclk_en, frame_sync, dac_load}), 0);
    rst = 1'b0;
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!frame_sync && k < 5000);
    chk(k == 2047, "R4 first frame after reset", k, 2047);
    // R4: default settings
    measure(1, 8, 2048, 8);

    // R1: master divider sweep, reserved codes included
    for (int mc = 0; mc < 8; mc++) begin
      set_cfg(mc, 1, 3, 0, 1'b0);
      measure(m_of(mc), 4, 256, 4);
    end
    // R2: serial rate sweep
    for (int sc = 0; sc < 4; sc++) begin
      set_cfg(1, sc, 3, 0, 1'b0);
      measure(2, s_of(sc), 256, d_of(s_of(sc), 256, 0));
    end
    // R3: sample rate sweep, R6 step scales with N
    for (int rc = 0; rc < 4; rc++) begin
      set_cfg(0, 0, rc, 3, 1'b0);
      measure(1, 8, n_of(rc), d_of(8, n_of(rc), 3));
    end
    // R6: advance corner values
    set_cfg(0, 0, 3, 31, 1'b0);
    measure(1, 8, 256, d_of(8, 256, 31));
    set_cfg(0, 0, 3, 30, 1'b0);
    measure(1, 8, 256, d_of(8, 256, 30));
    set_cfg(2, 3, 3, 31, 1'b0);
    measure(3, 1, 256, d_of(1, 256, 31));
    set_cfg(0, 2, 2, 1, 1'b0);
    measure(1, 2, 512, d_of(2, 512, 1));

    // R8: advance held while the DAC is powered
    set_cfg(0, 0, 3, 5, 1'b0);
    measure(1, 8, 256, d_of(8, 256, 5));
    set_cfg(0, 0, 3, 20, 1'b1);
    measure(1, 8, 256, d_of(8, 256, 5));
    set_cfg(0, 0, 3, 20, 1'b0);
    measure(1, 8, 256, d_of(8, 256, 20));

    // R7: mid-frame change leaves current frame length alone
    set_cfg(0, 0, 3, 0, 1'b0);
    measure(1, 8, 256, 8);
    wait_fs();
    set_cfg(1, 0, 2, 0, 1'b0);
    k = 1;
    while (!frame_sync && k < 5000) begin
      @(negedge clk);
      k++;
    end
    chk(k == 256, "R7 frame in progress keeps length", k, 256);
    measure(2, 8, 512, 8);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule